// File: doc/BRIEF.md
# Digital Input Interrupt Controller

This block monitors a set of asynchronous digital input lines and raises one interrupt request when any enabled line meets its configured trigger condition. Each line is first brought into the clock domain by a synchronizer chain. A detector per line then looks for one of two conditions. In level mode, the synchronized line holds a chosen active level. In change-of-state mode, the line has just moved in either direction.

Software sets up each line through a small word-addressed register bus with byte-lane enables. Each line has four controls: an enable mask, a trigger-type select, a level-polarity select and a sticky pending flag. The pending flag is cleared by writing a one to its bit. The interrupt output is a registered OR of every pending flag whose line is enabled. A typical handler reads the pending word, services the lines it finds, and writes the same word back to clear them.

Top module: `dio_irq_ctrl`

## Requirements
- R1: After reset, the enable, type, polarity and pending registers all read zero, and `irq_o` is low.
- R2: A write changes register bits only in byte lanes whose `bus_be_i` bit is set. A write with lane 0 disabled leaves channels 0 to 7 unchanged.
- R3: Register bits at or above the channel count always read as zero.
- R4: With type bit 0 (level mode), the pending bit sets while the synchronized input equals the polarity bit, where polarity 1 means active high and 0 means active low.
- R5: With type bit 1 (change-of-state mode), the pending bit sets on a rising or a falling input transition. A steady input does not set it again.
- R6: A channel whose enable bit is 0 never sets its pending bit. Clearing an enable bit drops that channel's contribution to `irq_o`.
- R7: Writing 1 to a pending bit clears it, and writing 0 has no effect. In level mode the bit sets again at once while the active level is still present.
- R8: `irq_o` is the registered OR of pending AND enable. An input change driven before a rising edge reaches `irq_o` on the fourth rising edge.
- R9: The registers sit at these word addresses on `bus_addr_i`: 0 is enable, 1 is type, 2 is polarity and 3 is pending. Channel n maps to data bit n. `bus_rdata_o` is valid on the edge after `bus_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din_i | input | NUM_CH | Asynchronous input lines |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | DW | Write data |
| bus_be_i | input | DW/8 | Byte-lane write enables |
| bus_rdata_o | output | DW | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets four corner cases.

The first is a level channel cleared while its level persists. It must reappear at once; a design that latched only edges would lose it.

The second is a change-of-state channel. It must catch both the rising and the falling transition but stay quiet on a held level. A design that compared against polarity, or detected only one edge, fails this.

The third covers writes with lane 0 disabled and writes of zero to the pending word. Each must leave state untouched, which exposes a design that ignores byte enables or toggles bits instead of clearing them.

The fourth measures the exact four-edge latency from input to `irq_o`. It also confirms that a disabled channel never shows as pending, which catches a missing synchronizer stage or an ungated pending flag.

// File: rtl/dio_irq_pkg.sv
package dio_irq_pkg;
  localparam int REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_EN   = 2'd0,
    REG_TYPE = 2'd1,
    REG_POL  = 2'd2,
    REG_PEND = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] smp_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] chain [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[STAGES-1];
  end

  assign smp_o  = chain[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/dio_trig_chan.sv
module dio_trig_chan (
  input  logic clk,
  input  logic rst,
  input  logic smp_i,
  input  logic prev_i,
  input  logic en_i,
  input  logic cos_mode_i,
  input  logic pol_i,
  input  logic clr_i,
  output logic pend_o
);
  logic hit;
  logic pend_q;

  always_comb begin
    if (cos_mode_i) hit = (smp_i != prev_i);
    else            hit = (smp_i == pol_i);
  end

  // a new event outranks a clear arriving on the same edge
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q & ~clr_i) | (hit & en_i);
  end

  assign pend_o = pend_q;

  assert_level_sets_R4: assert property (@(posedge clk) disable iff (rst)
    (en_i && !cos_mode_i && (smp_i == pol_i)) |=> pend_o);

  assert_cos_sets_R5: assert property (@(posedge clk) disable iff (rst)
    (en_i && cos_mode_i && (smp_i != prev_i)) |=> pend_o);

  assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_o) |-> $past(en_i));

  assert_drop_needs_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_o) |-> $past(clr_i));
endmodule

// File: rtl/dio_regbank.sv
module dio_regbank
  import dio_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic [DW/8-1:0]   bus_be_i,
  output logic [DW-1:0]     bus_rdata_o,
  input  logic [NUM_CH-1:0] pend_i,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] type_o,
  output logic [NUM_CH-1:0] pol_o,
  output logic [NUM_CH-1:0] clr_o
);
  localparam int LANE0_HI = ((NUM_CH < 8) ? NUM_CH : 8) - 1;

  logic [NUM_CH-1:0] en_q, type_q, pol_q;
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     rdata_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(bus_addr_i);

  genvar i;
  generate
    for (i = 0; i < NUM_CH; i++) begin : g_bit
      localparam int LANE = i / 8;
      logic lane_wr;
      assign lane_wr = bus_wr_i & bus_be_i[LANE];

      always_ff @(posedge clk) begin
        if (rst) begin
          en_q[i]   <= 1'b0;
          type_q[i] <= 1'b0;
          pol_q[i]  <= 1'b0;
        end else if (lane_wr) begin
          if (sel == REG_EN)   en_q[i]   <= bus_wdata_i[i];
          if (sel == REG_TYPE) type_q[i] <= bus_wdata_i[i];
          if (sel == REG_POL)  pol_q[i]  <= bus_wdata_i[i];
        end
      end

      assign clr_o[i] = lane_wr & (sel == REG_PEND) & bus_wdata_i[i];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_EN:   rd_mux[NUM_CH-1:0] = en_q;
      REG_TYPE: rd_mux[NUM_CH-1:0] = type_q;
      REG_POL:  rd_mux[NUM_CH-1:0] = pol_q;
      default:  rd_mux[NUM_CH-1:0] = pend_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign en_o   = en_q;
  assign type_o = type_q;
  assign pol_o  = pol_q;

  assert_lane_masked_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && !bus_be_i[0]) |=> ($stable(en_q[LANE0_HI:0]) &&
      $stable(type_q[LANE0_HI:0]) && $stable(pol_q[LANE0_HI:0])));

  generate
    if (NUM_CH < DW) begin : g_upper
      assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        bus_rdata_o[DW-1:NUM_CH] == '0);
    end
  endgenerate
endmodule

// File: rtl/dio_irq_ctrl.sv
module dio_irq_ctrl
  import dio_irq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] din_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic [DW/8-1:0]   bus_be_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] smp, prev, en, typ, pol, clr, pend;
  logic              irq_q;

  dio_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(din_i), .smp_o(smp), .prev_o(prev)
  );

  dio_regbank #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
    .clk(clk), .rst(rst),
    .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_be_i(bus_be_i), .bus_rdata_o(bus_rdata_o),
    .pend_i(pend), .en_o(en), .type_o(typ), .pol_o(pol), .clr_o(clr)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_chan
      dio_trig_chan u_chan (
        .clk(clk), .rst(rst), .smp_i(smp[c]), .prev_i(prev[c]),
        .en_i(en[c]), .cos_mode_i(typ[c]), .pol_i(pol[c]),
        .clr_i(clr[c]), .pend_o(pend[c])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend & en);
  end

  assign irq_o = irq_q;

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |=> !irq_o);
endmodule

// File: tb/test_dio_irq_ctrl.sv
module test_dio_irq_ctrl;
  localparam int NUM_CH = 8;
  localparam int DW     = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NUM_CH-1:0] din = '0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [1:0]        addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic [DW/8-1:0]   be = '0;
  logic [DW-1:0]     rdata;
  logic              irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  dio_irq_ctrl #(.NUM_CH(NUM_CH), .DW(DW), .SYNC_STAGES(2)) i_dio_irq_ctrl (
    .clk(clk), .rst(rst), .din_i(din), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_be_i(be),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [1:0] A_EN = 2'd0, A_TYPE = 2'd1, A_POL = 2'd2, A_PEND = 2'd3;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; din = '0; wr = 0; rd = 0; be = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(A_EN, d);   chk("R1 enable reset", d, 32'h0);
    bus_read(A_TYPE, d); chk("R1 type reset", d, 32'h0);
    bus_read(A_POL, d);  chk("R1 polarity reset", d, 32'h0);
    bus_read(A_PEND, d); chk("R1 pending reset", d, 32'h0);
  endtask

  task automatic t_bytes();
    logic [31:0] d;
    do_reset();
    bus_write(A_POL, 32'hFFFF_FFA5, 4'b1110);
    bus_read(A_POL, d); chk("R2 lane0 masked write", d, 32'h0);
    bus_write(A_POL, 32'hFFFF_FFA5, 4'b0001);
    bus_read(A_POL, d); chk("R3 upper bits zero, R9 bit map", d, 32'h0000_00A5);
    bus_write(A_TYPE, 32'h0000_005A, 4'b1111);
    bus_read(A_TYPE, d); chk("R9 type address", d, 32'h0000_005A);
    bus_read(A_POL, d);  chk("R9 polarity untouched", d, 32'h0000_00A5);
  endtask

  task automatic t_level();
    logic [31:0] d;
    do_reset();
    bus_write(A_POL, 32'h01, 4'h1);
    bus_write(A_EN, 32'h01, 4'h1);
    idle(6);
    bus_read(A_PEND, d); chk("R4 high level not yet present", d, 32'h0);
    chk("R4 irq quiet", {31'b0, irq}, 32'h0);
    din[0] = 1'b1;
    idle(6);
    bus_read(A_PEND, d); chk("R4 active-high level sets", d, 32'h01);
    chk("R4 irq raised", {31'b0, irq}, 32'h1);
    bus_write(A_EN, 32'h03, 4'h1);
    idle(5);
    bus_read(A_PEND, d); chk("R4 active-low level sets", d, 32'h03);
  endtask

  task automatic t_cos();
    logic [31:0] d;
    do_reset();
    bus_write(A_TYPE, 32'h08, 4'h1);
    bus_write(A_EN, 32'h08, 4'h1);
    idle(5);
    bus_read(A_PEND, d); chk("R5 steady low no event", d, 32'h0);
    din[3] = 1'b1;
    idle(6);
    bus_read(A_PEND, d); chk("R5 rising sets", d, 32'h08);
    bus_write(A_PEND, 32'h08, 4'h1);
    idle(5);
    bus_read(A_PEND, d); chk("R5 steady high stays clear", d, 32'h0);
    din[3] = 1'b0;
    idle(6);
    bus_read(A_PEND, d); chk("R5 falling sets", d, 32'h08);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    do_reset();
    bus_write(A_POL, 32'h01, 4'h1);
    bus_write(A_EN, 32'h01, 4'h1);
    din[0] = 1'b1;
    idle(6);
    bus_write(A_PEND, 32'h00, 4'h1);
    bus_read(A_PEND, d); chk("R7 write zero no effect", d, 32'h01);
    bus_write(A_PEND, 32'h01, 4'h1);
    bus_read(A_PEND, d); chk("R7 level re-sets after clear", d, 32'h01);
    din[0] = 1'b0;
    idle(5);
    bus_write(A_PEND, 32'h01, 4'h1);
    bus_read(A_PEND, d); chk("R7 clear sticks when level gone", d, 32'h0);
    idle(2);
    chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    do_reset();
    bus_write(A_POL, 32'hFF, 4'h1);
    din = 8'hFF;
    idle(6);
    bus_read(A_PEND, d); chk("R6 disabled channels never pend", d, 32'h0);
    chk("R6 irq low while disabled", {31'b0, irq}, 32'h0);
    bus_write(A_EN, 32'h10, 4'h1);
    idle(4);
    bus_read(A_PEND, d); chk("R6 only enabled channel pends", d, 32'h10);
    chk("R6 irq high", {31'b0, irq}, 32'h1);
    bus_write(A_EN, 32'h00, 4'h1);
    idle(2);
    chk("R6 irq drops when enable cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    do_reset();
    bus_write(A_TYPE, 32'h04, 4'h1);
    bus_write(A_EN, 32'h04, 4'h1);
    idle(3);
    chk("R8 irq idle before change", {31'b0, irq}, 32'h0);
    @(negedge clk);
    din[2] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 irq low after three edges", {31'b0, irq}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 irq high on fourth edge", {31'b0, irq}, 32'h1);
    bus_read(A_PEND, d); chk("R8 pending matches", d, 32'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog R1..all: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_bytes();
    t_level();
    t_cos();
    t_w1c();
    t_enable();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule